// File: doc/BRIEF.md
# Synthesizer Reference Divider and Phase Comparator

This block is the digital heart of a frequency-synthesizer loop. A 75 kHz crystal timebase arrives as a one-cycle enable (`xtal_tick`) in the system clock domain. A reference divider turns it into a comparison pulse at one of six rates: 1, 3, 5, 6.25, 12.5 or 25 kHz. A two-flag phase-frequency comparator sets a flag for whichever event arrives first: the comparison pulse or the pre-divided oscillator pulse (`osc_pulse`, already synchronous). It clears both flags once the other event arrives. The flags drive a three-state charge-pump command: float, drive high or drive low.

A lock monitor counts the cycles in which the pump is driven within one comparison period. When that count exceeds a programmable dead-band, it raises a sticky unlock flag, which stays set until the clear strobe. The low-power modes (halt, PLL stop and backup) force the pump to float and park the divider and the comparator. Reset does the same.

Top module: `pll_synth_core`

## Requirements
- R1: After reset, `pump_code` is 00 (float), `ref_pulse` is 0 and `unlock_flag` is 0.
- R2: `ref_pulse` is high for one clock, in the cycle after the N-th sampled `xtal_tick` of a period. N comes from `ref_sel`: 0→75, 1→25, 2→15, 3→12, 4→6, 5→3, and 6 or 7→75.
- R3: A change of `ref_sel` applies to the running period. If the ticks already counted reach or pass the new N−1, the next tick ends the period.
- R4: A sampled `osc_pulse` with no pending reference event makes `pump_code` 01 (drive high) from the next cycle. It stays 01 until the reference event arrives.
- R5: A sampled `ref_pulse` with no pending oscillator event makes `pump_code` 10 (drive low) from the next cycle. It stays 10 until an oscillator event arrives.
- R6: When the second event of a pair is sampled, both flags clear and `pump_code` is 00 in the next cycle. Events sampled in the same cycle leave the pump floating. The code 11 never appears.
- R7: The lock monitor keeps a count that restarts at each sampled `ref_pulse` cycle and adds one for each cycle in which the pump is driven. `unlock_flag` rises in the cycle after that count first exceeds `deadband`.
- R8: `unlock_flag` stays set until a sampled `unlock_clr`. If a new excess is detected in the same cycle as the clear, the flag stays set.
- R9: While any of `halt_mode`, `stop_mode` or `backup_mode` is high, `pump_code` is 00 in that same cycle. The divider count, the comparator flags and the lock count are cleared, and `unlock_flag` is held (only `unlock_clr` can clear it).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| xtal_tick | input | 1 | One-cycle enable per 75 kHz crystal period |
| ref_sel | input | 3 | Comparison-rate select code |
| osc_pulse | input | 1 | One-cycle pulse from the pre-divided oscillator |
| deadband | input | DB_W (8) | Allowed driven cycles per comparison period |
| unlock_clr | input | 1 | Clear strobe for the unlock flag |
| halt_mode | input | 1 | Halt mode: pump floats |
| stop_mode | input | 1 | PLL stop mode: pump floats |
| backup_mode | input | 1 | Backup mode: pump floats |
| pump_code | output | 2 | 00 float, 01 drive high, 10 drive low |
| ref_pulse | output | 1 | Comparison pulse from the reference divider |
| unlock_flag | output | 1 | Sticky unlock indication |

## Verification
The bench uses the default `DB_W` of 8, so `deadband` can go from 0 up to 255. Crystal ticks arrive every fourth clock. With the fastest select, a comparison period is then only 12 cycles. This puts the exact dead-band edge (11 against 12 driven cycles) and the set-over-clear collision at `deadband` 0 within short directed runs. The same short period lets a long random run visit every select code, including the two that fall back to 75, along with mode pulses and clear strobes.

// File: rtl/pll_synth_pkg.sv
package pll_synth_pkg;

    localparam int SEL_W  = 3;
    localparam int RDIV_W = 7;

    typedef enum logic [1:0] {
        PUMP_FLOAT = 2'b00,
        PUMP_HIGH  = 2'b01,
        PUMP_LOW   = 2'b10
    } pump_e;

    typedef struct packed {
        logic up;   // oscillator event is pending
        logic dn;   // reference event is pending
    } pfd_state_t;

    // Divide ratio from the 75 kHz timebase for each select code
    function automatic logic [RDIV_W-1:0] ref_ratio(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd1:    return RDIV_W'(25);
            3'd2:    return RDIV_W'(15);
            3'd3:    return RDIV_W'(12);
            3'd4:    return RDIV_W'(6);
            3'd5:    return RDIV_W'(3);
            default: return RDIV_W'(75);
        endcase
    endfunction

    function automatic pump_e pump_encode(input pfd_state_t st, input logic force_float);
        if (force_float)  return PUMP_FLOAT;
        else if (st.up)   return PUMP_HIGH;
        else if (st.dn)   return PUMP_LOW;
        else              return PUMP_FLOAT;
    endfunction

endpackage

// File: rtl/pll_ref_div.sv
module pll_ref_div
    import pll_synth_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             xtal_tick,
    input  logic [SEL_W-1:0] sel,
    output logic             ref_pulse
);
    logic [RDIV_W-1:0] cnt;
    logic [RDIV_W-1:0] ratio;
    logic              wrap;

    always_comb begin
        ratio = ref_ratio(sel);
        wrap  = xtal_tick && (cnt >= ratio - RDIV_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt       <= '0;
            ref_pulse <= 1'b0;
        end else begin
            ref_pulse <= wrap;
            if (xtal_tick)
                cnt <= wrap ? '0 : cnt + RDIV_W'(1);
        end
    end
endmodule

// File: rtl/pll_pfd.sv
module pll_pfd
    import pll_synth_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hold,
    input  logic       ref_ev,
    input  logic       osc_ev,
    output pfd_state_t st
);
    pfd_state_t nxt;

    always_comb begin
        nxt.up = st.up | osc_ev;
        nxt.dn = st.dn | ref_ev;
        if (nxt.up && nxt.dn)
            nxt = '0;
    end

    always_ff @(posedge clk) begin
        if (rst || hold) st <= '0;
        else             st <= nxt;
    end
endmodule

// File: rtl/pll_lock_mon.sv
module pll_lock_mon #(
    parameter int DB_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hold,
    input  logic            active,
    input  logic            period_start,
    input  logic [DB_W-1:0] deadband,
    input  logic            clr,
    output logic            unlock
);
    localparam int CW = DB_W + 1;

    logic [CW-1:0] run;
    logic [CW-1:0] base;
    logic [CW-1:0] nxt;
    logic          excess;

    always_comb begin
        base   = period_start ? '0 : run;
        nxt    = (&base) ? base : base + CW'(active);
        excess = !hold && (nxt > {1'b0, deadband});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run    <= '0;
            unlock <= 1'b0;
        end else begin
            run <= hold ? '0 : nxt;
            if (excess)   unlock <= 1'b1;
            else if (clr) unlock <= 1'b0;
        end
    end
endmodule

// File: rtl/pll_synth_core.sv
module pll_synth_core
    import pll_synth_pkg::*;
#(
    parameter int DB_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            xtal_tick,
    input  logic [2:0]      ref_sel,
    input  logic            osc_pulse,
    input  logic [DB_W-1:0] deadband,
    input  logic            unlock_clr,
    input  logic            halt_mode,
    input  logic            stop_mode,
    input  logic            backup_mode,
    output logic [1:0]      pump_code,
    output logic            ref_pulse,
    output logic            unlock_flag
);
    logic       hold;
    pfd_state_t pfd_st;

    assign hold = halt_mode | stop_mode | backup_mode;

    pll_ref_div u_div (
        .clk       (clk),
        .rst       (rst),
        .hold      (hold),
        .xtal_tick (xtal_tick),
        .sel       (ref_sel),
        .ref_pulse (ref_pulse)
    );

    pll_pfd u_pfd (
        .clk    (clk),
        .rst    (rst),
        .hold   (hold),
        .ref_ev (ref_pulse),
        .osc_ev (osc_pulse),
        .st     (pfd_st)
    );

    pll_lock_mon #(.DB_W(DB_W)) u_lock (
        .clk          (clk),
        .rst          (rst),
        .hold         (hold),
        .active       (pfd_st.up | pfd_st.dn),
        .period_start (ref_pulse),
        .deadband     (deadband),
        .clr          (unlock_clr),
        .unlock       (unlock_flag)
    );

    assign pump_code = pump_encode(pfd_st, hold);
endmodule

// File: rtl/pll_synth_core_chk.sv
module pll_synth_core_chk (
    input logic       clk,
    input logic       rst,
    input logic       halt_mode,
    input logic       stop_mode,
    input logic       backup_mode,
    input logic       osc_pulse,
    input logic       unlock_clr,
    input logic       ref_pulse,
    input logic       unlock_flag,
    input logic [1:0] pump_code
);
    assert_float_in_modes_R9: assert property (@(posedge clk) disable iff (rst)
        (halt_mode || stop_mode || backup_mode) |-> pump_code == 2'b00);

    assert_no_code_11_R6: assert property (@(posedge clk) disable iff (rst)
        pump_code != 2'b11);

    assert_pair_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (pump_code == 2'b01 && ref_pulse) |=> pump_code == 2'b00);

    assert_osc_first_high_R4: assert property (@(posedge clk) disable iff (rst)
        (pump_code == 2'b00 && osc_pulse && !ref_pulse &&
         !halt_mode && !stop_mode && !backup_mode) |=>
        (pump_code == 2'b01 || halt_mode || stop_mode || backup_mode));

    assert_ref_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        ref_pulse |=> !ref_pulse);

    assert_unlock_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (unlock_flag && !unlock_clr) |=> unlock_flag);

    assert_unlock_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(unlock_flag) |-> $past(pump_code) != 2'b00);
endmodule

bind pll_synth_core pll_synth_core_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .halt_mode   (halt_mode),
    .stop_mode   (stop_mode),
    .backup_mode (backup_mode),
    .osc_pulse   (osc_pulse),
    .unlock_clr  (unlock_clr),
    .ref_pulse   (ref_pulse),
    .unlock_flag (unlock_flag),
    .pump_code   (pump_code)
);

// File: tb/pll_synth_core_tb_top.sv
module pll_synth_core_tb_top;
    localparam int DB_W = 8;
    localparam int TICK_GAP = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst = 1'b1;
    logic            xtal_tick = 1'b0;
    logic [2:0]      ref_sel = 3'd5;
    logic            osc_pulse = 1'b0;
    logic [DB_W-1:0] deadband = '1;
    logic            unlock_clr = 1'b0;
    logic            halt_mode = 1'b0, stop_mode = 1'b0, backup_mode = 1'b0;
    logic [1:0]      pump_code;
    logic            ref_pulse, unlock_flag;

    pll_synth_core #(.DB_W(DB_W)) dut_i (
        .clk(clk), .rst(rst), .xtal_tick(xtal_tick), .ref_sel(ref_sel),
        .osc_pulse(osc_pulse), .deadband(deadband), .unlock_clr(unlock_clr),
        .halt_mode(halt_mode), .stop_mode(stop_mode), .backup_mode(backup_mode),
        .pump_code(pump_code), .ref_pulse(ref_pulse), .unlock_flag(unlock_flag)
    );

    int errors = 0, checks = 0;
    int tick_phase = 0;
    int tick_seen = 0;
    bit done = 0;

    // behavioural reference model
    int m_cnt = 0, m_act = 0;
    bit m_refp = 0, m_up = 0, m_dn = 0, m_unl = 0;

    function automatic int ratio_of(input int s);
        int r;
        case (s)
            1: r = 25; 2: r = 15; 3: r = 12; 4: r = 6; 5: r = 3;
            default: r = 75;
        endcase
        return r;
    endfunction

    always @(posedge clk) begin
        bit idle, nref, u, d, setf;
        int cn, base;
        idle = halt_mode || stop_mode || backup_mode;
        if (rst || idle) tick_seen = 0;
        else if (xtal_tick) tick_seen++;
        if (rst) begin
            m_cnt = 0; m_act = 0; m_refp = 0; m_up = 0; m_dn = 0; m_unl = 0;
        end else if (idle) begin
            m_cnt = 0; m_act = 0; m_refp = 0; m_up = 0; m_dn = 0;
            if (unlock_clr) m_unl = 0;
        end else begin
            nref = xtal_tick && (m_cnt >= ratio_of(ref_sel) - 1);
            if (xtal_tick) m_cnt = nref ? 0 : m_cnt + 1;
            base = m_refp ? 0 : m_act;
            cn = base + ((m_up || m_dn) ? 1 : 0);
            if (cn > 511) cn = 511;
            setf = cn > deadband;
            m_act = cn;
            u = m_up || osc_pulse;
            d = m_dn || m_refp;
            if (u && d) begin u = 0; d = 0; end
            m_up = u; m_dn = d;
            if (setf) m_unl = 1;
            else if (unlock_clr) m_unl = 0;
            m_refp = nref;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // one cycle: compare at the falling edge, then set up the next edge's inputs
    task automatic cyc();
        int ep;
        @(negedge clk);
        ep = (halt_mode || stop_mode || backup_mode) ? 0 : (m_up ? 1 : (m_dn ? 2 : 0));
        chk(ref_pulse == m_refp, "R2 ref_pulse", ref_pulse, m_refp);
        chk(pump_code == ep,     "R4 pump_code", pump_code, ep);
        chk(unlock_flag == m_unl,"R7 unlock_flag", unlock_flag, m_unl);
        osc_pulse = 0; unlock_clr = 0;
        tick_phase = (tick_phase + 1) % TICK_GAP;
        xtal_tick = (tick_phase == 0);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wait_ref();
        for (int i = 0; i < 1000 && !ref_pulse; i++) cyc();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        run(3);
        chk(pump_code == 0 && ref_pulse == 0 && unlock_flag == 0, "R1 reset state",
            {pump_code, ref_pulse, unlock_flag}, 0);
        rst = 0;

        // R2: period with select 5 is 3 ticks
        wait_ref(); cyc();
        n = 1;
        while (!ref_pulse && n < 1000) begin cyc(); n++; end
        chk(n == 3 * TICK_GAP, "R2 period sel5", n, 3 * TICK_GAP);
        cyc();
        chk(pump_code == 2, "R5 ref first drives low", pump_code, 2);
        osc_pulse = 1; cyc();
        chk(pump_code == 0, "R6 second event clears", pump_code, 0);

        // R6 simultaneous events
        wait_ref(); osc_pulse = 1; cyc();
        chk(pump_code == 0, "R6 simultaneous stays float", pump_code, 0);
        run(2); osc_pulse = 1; cyc();
        chk(pump_code == 1, "R4 osc first drives high", pump_code, 1);
        run(3);
        chk(pump_code == 1, "R4 high held", pump_code, 1);
        wait_ref(); cyc();
        chk(pump_code == 0, "R6 ref completes pair", pump_code, 0);

        // R7 dead-band boundary: 12 driven cycles per period
        deadband = 8'd12; run(40);
        chk(unlock_flag == 0, "R7 no unlock at 12", unlock_flag, 0);
        deadband = 8'd11; run(20);
        chk(unlock_flag == 1, "R7 unlock above 11", unlock_flag, 1);

        // R8 sticky and set-over-clear
        deadband = '1; run(20);
        chk(unlock_flag == 1, "R8 sticky", unlock_flag, 1);
        deadband = 8'd0; unlock_clr = 1; cyc();
        chk(unlock_flag == 1, "R8 set wins over clear", unlock_flag, 1);

        // R9 modes force float and hold the flag
        halt_mode = 1; #1;
        chk(pump_code == 0, "R9 halt floats", pump_code, 0);
        cyc();
        chk(unlock_flag == 1, "R9 flag held in halt", unlock_flag, 1);
        unlock_clr = 1; cyc();
        chk(unlock_flag == 0, "R8 clear works", unlock_flag, 0);
        halt_mode = 0; stop_mode = 1; #1;
        chk(pump_code == 0, "R9 stop floats", pump_code, 0);
        cyc(); stop_mode = 0; backup_mode = 1; #1;
        chk(pump_code == 0, "R9 backup floats", pump_code, 0);
        cyc(); backup_mode = 0; deadband = '1;

        // R3 select change during a running period
        ref_sel = 3'd0; halt_mode = 1; cyc(); halt_mode = 0;
        for (int i = 0; i < 2000 && tick_seen < 20; i++) cyc();
        ref_sel = 3'd4;
        wait_ref();
        chk(tick_seen == 21, "R3 shorter ratio ends period", tick_seen, 21);

        // randomized run against the model
        for (int i = 0; i < 6000; i++) begin
            cyc();
            if (i % 500 == 0) ref_sel = 3'($urandom_range(0, 7));
            if (i % 300 == 0) deadband = 8'($urandom_range(0, 40));
            osc_pulse   = ($urandom_range(0, 9) == 0);
            unlock_clr  = ($urandom_range(0, 49) == 0);
            halt_mode   = ($urandom_range(0, 199) == 0);
            stop_mode   = ($urandom_range(0, 299) == 0);
            backup_mode = ($urandom_range(0, 299) == 0);
        end
        halt_mode = 0; stop_mode = 0; backup_mode = 0;
        run(5);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule